// File: doc/BRIEF.md
# Compressed Control-Flow Next-PC Unit

This block owns the program counter for a core that executes 16-bit instructions. For each valid strobe it takes an already decoded operation code, a sign-extended immediate and the value read from the source register. From these it computes the next program counter and, for the two linking jumps, the request to write the return address into the link register. All outputs are registered and change on the clock edge that samples the strobe. When the strobe is low the program counter holds its value.

The return address and the fall-through address are both the current PC plus 2, because every instruction handled here is two bytes long. A conditional branch tests a single register against zero. The decoder restricts that register to the eight-register subset x8 to x15, and this unit only sees its value. Register-indirect jumps clear bit 0 of the register value to form the target. Instruction decoding, register-file access and the handling of misaligned targets belong to the neighbouring blocks.

Top module: `cnpc_unit`

## Requirements
- R1: After a synchronous reset, pc_o equals the parameter RESET_VEC (default 0x0000_1000), link_we_o is 0 and link_idx_o is 0.
- R2: Operation code 3 (indirect jump) loads pc_o with src_i with bit 0 forced to 0 and writes no link.
- R3: Operation code 4 (indirect jump with link) loads pc_o with src_i with bit 0 cleared, and sets link_we_o=1, link_idx_o=1 and link_val_o = old pc + 2.
- R4: Operation code 2 (relative jump with link) loads pc_o with pc + imm_i, and sets link_we_o=1, link_idx_o=1 and link_val_o = old pc + 2.
- R5: Operation code 1 (relative jump without link) loads pc_o with pc + imm_i and leaves link_we_o at 0 and link_idx_o at 0, so it never requests a write to a nonzero register.
- R6: Operation code 5 branches to pc + imm_i when src_i is zero and otherwise goes to pc + 2. Operation code 6 branches when src_i is nonzero and otherwise goes to pc + 2. Neither writes a link.
- R7: Operation codes 0 and 7 (any non-control-flow compressed instruction) advance pc_o by 2 with link_we_o at 0.
- R8: While valid_i is low, pc_o keeps its value and link_we_o is 0 one cycle later.
- R9: All address sums wrap modulo 2^XLEN, and negative immediates move the PC backwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe: an instruction retires this cycle |
| op_i | input | 3 | Decoded operation code (see R2 to R7) |
| imm_i | input | XLEN | Sign-extended jump or branch offset |
| src_i | input | XLEN | Source register value |
| pc_o | output | XLEN | Registered program counter |
| link_we_o | output | 1 | Registered link-register write request |
| link_idx_o | output | REG_IDX_W | Link register index, 1 when writing, else 0 |
| link_val_o | output | XLEN | Return address, old PC + 2 |

## Verification
The assertions assume that op_i, imm_i and src_i carry known values whenever valid_i is high, and that valid_i itself is known from reset onwards. The bench changes inputs only on the falling edge, holds valid_i high for exactly one rising edge per instruction, and returns it to 0 between instructions. The bench always passes even immediates, which is what a decoder produces, so that the only odd values reaching the unit come through src_i, the operand the bit-0 clearing rule is meant for.

// File: rtl/cnpc_pkg.sv
package cnpc_pkg;
  typedef enum logic [2:0] {
    CF_SEQ   = 3'd0,
    CF_J     = 3'd1,
    CF_JAL   = 3'd2,
    CF_JR    = 3'd3,
    CF_JALR  = 3'd4,
    CF_BEQZ  = 3'd5,
    CF_BNEZ  = 3'd6,
    CF_SEQ2  = 3'd7
  } cf_op_e;

  localparam int unsigned INSN_BYTES = 2;
  localparam int unsigned LINK_REG   = 1;
endpackage

// File: rtl/cnpc_cond.sv
module cnpc_cond
  import cnpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cf_op_e            op,
  input  logic [XLEN-1:0]   src,
  output logic              take_rel,
  output logic              take_ind
);
  logic src_zero;

  assign src_zero = (src == '0);

  always_comb begin
    take_rel = 1'b0;
    take_ind = 1'b0;
    unique case (op)
      CF_J, CF_JAL:     take_rel = 1'b1;
      CF_BEQZ:          take_rel = src_zero;
      CF_BNEZ:          take_rel = !src_zero;
      CF_JR, CF_JALR:   take_ind = 1'b1;
      default: begin
        take_rel = 1'b0;
        take_ind = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cnpc_target.sv
module cnpc_target #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned STEP      = 2,
  parameter int unsigned ALIGN_LSB = 1
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] src,
  input  logic            take_rel,
  input  logic            take_ind,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] seq_pc
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] ind_pc;

  assign seq_pc = pc + STEP_V;
  assign rel_pc = pc + imm;

  generate
    if (ALIGN_LSB > 0) begin : g_mask
      localparam logic [XLEN-1:0] MASK = ~XLEN'((1 << ALIGN_LSB) - 1);
      assign ind_pc = src & MASK;
    end else begin : g_nomask
      assign ind_pc = src;
    end
  endgenerate

  always_comb begin
    if (take_ind)      next_pc = ind_pc;
    else if (take_rel) next_pc = rel_pc;
    else               next_pc = seq_pc;
  end
endmodule

// File: rtl/cnpc_link.sv
module cnpc_link
  import cnpc_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5
) (
  input  cf_op_e               op,
  output logic                 we,
  output logic [REG_IDX_W-1:0] idx
);
  always_comb begin
    we  = (op == CF_JAL) || (op == CF_JALR);
    idx = we ? REG_IDX_W'(LINK_REG) : '0;
  end
endmodule

// File: rtl/cnpc_unit.sv
module cnpc_unit
  import cnpc_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     REG_IDX_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [XLEN-1:0]      imm_i,
  input  logic [XLEN-1:0]      src_i,
  output logic [XLEN-1:0]      pc_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]      link_val_o
);
  cf_op_e                op;
  logic                  take_rel;
  logic                  take_ind;
  logic [XLEN-1:0]       next_pc;
  logic [XLEN-1:0]       seq_pc;
  logic                  lk_we;
  logic [REG_IDX_W-1:0]  lk_idx;

  assign op = cf_op_e'(op_i);

  cnpc_cond #(.XLEN(XLEN)) u_cond (
    .op       (op),
    .src      (src_i),
    .take_rel (take_rel),
    .take_ind (take_ind)
  );

  cnpc_target #(.XLEN(XLEN), .STEP(INSN_BYTES), .ALIGN_LSB(1)) u_target (
    .pc       (pc_o),
    .imm      (imm_i),
    .src      (src_i),
    .take_rel (take_rel),
    .take_ind (take_ind),
    .next_pc  (next_pc),
    .seq_pc   (seq_pc)
  );

  cnpc_link #(.REG_IDX_W(REG_IDX_W)) u_link (
    .op  (op),
    .we  (lk_we),
    .idx (lk_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o       <= RESET_VEC;
      link_we_o  <= 1'b0;
      link_idx_o <= '0;
      link_val_o <= '0;
    end else if (valid_i) begin
      pc_o       <= next_pc;
      link_we_o  <= lk_we;
      link_idx_o <= lk_idx;
      link_val_o <= seq_pc;
    end else begin
      link_we_o  <= 1'b0;
      link_idx_o <= '0;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(pc_o) && !link_we_o)); // R8

  AST_IND_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 3'd3 || op_i == 3'd4)) |=> (pc_o[0] == 1'b0)); // R2

  AST_JALR_LINK: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd4) |=> (link_we_o && link_val_o == $past(pc_o) + XLEN'(2))); // R3

  AST_JAL_LINK: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd2) |=> (link_we_o && pc_o == $past(pc_o) + $past(imm_i))); // R4

  AST_J_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd1) |=> (!link_we_o && link_idx_o == '0)); // R5

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 3'd0 || op_i == 3'd7)) |=> (pc_o == $past(pc_o) + XLEN'(2) && !link_we_o)); // R7

  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd5 && src_i != '0) |=> (pc_o == $past(pc_o) + XLEN'(2))); // R6

  AST_LINK_IDX: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_idx_o == REG_IDX_W'(1))); // R3
endmodule

// File: tb/cnpc_unit_test.sv
module cnpc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [31:0] imm_i;
  logic [31:0] src_i;
  logic [31:0] pc_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_val_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnpc_unit #(.XLEN(32), .REG_IDX_W(5), .RESET_VEC(RVEC)) uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .imm_i(imm_i),
    .src_i(src_i), .pc_o(pc_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_val_o(link_val_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [31:0] imm, input logic [31:0] src);
    @(negedge clk);
    op_i = op; imm_i = imm; src_i = src; valid_i = 1'b1;
    @(posedge clk);
    #1;
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pc", pc_o, RVEC);
    check("R1 we", {31'd0, link_we_o}, 32'd0);
    check("R1 idx", {27'd0, link_idx_o}, 32'd0);
    exp_pc = RVEC;
  endtask

  task automatic t_seq(input logic [2:0] code);
    step(code, 32'h0000_0100, 32'hDEAD_BEEF);
    exp_pc = exp_pc + 32'd2;
    check("R7 pc", pc_o, exp_pc);
    check("R7 we", {31'd0, link_we_o}, 32'd0);
  endtask

  task automatic t_jal(input logic [31:0] imm);
    logic [31:0] old = exp_pc;
    step(3'd2, imm, 32'h0);
    exp_pc = old + imm;
    check("R4 pc", pc_o, exp_pc);
    check("R4 we", {31'd0, link_we_o}, 32'd1);
    check("R4 idx", {27'd0, link_idx_o}, 32'd1);
    check("R4 val", link_val_o, old + 32'd2);
  endtask

  task automatic t_j(input logic [31:0] imm);
    step(3'd1, imm, 32'h5);
    exp_pc = exp_pc + imm;
    check("R5 R9 pc", pc_o, exp_pc);
    check("R5 we", {31'd0, link_we_o}, 32'd0);
    check("R5 idx", {27'd0, link_idx_o}, 32'd0);
  endtask

  task automatic t_jr(input logic [31:0] src);
    step(3'd3, 32'h40, src);
    exp_pc = src & 32'hFFFF_FFFE;
    check("R2 pc", pc_o, exp_pc);
    check("R2 we", {31'd0, link_we_o}, 32'd0);
  endtask

  task automatic t_jalr(input logic [31:0] src);
    logic [31:0] old = exp_pc;
    step(3'd4, 32'h40, src);
    exp_pc = src & 32'hFFFF_FFFE;
    check("R3 pc", pc_o, exp_pc);
    check("R3 we", {31'd0, link_we_o}, 32'd1);
    check("R3 idx", {27'd0, link_idx_o}, 32'd1);
    check("R3 val", link_val_o, old + 32'd2);
  endtask

  task automatic t_branch(input logic [2:0] code, input logic [31:0] imm, input logic [31:0] src);
    logic taken = (code == 3'd5) ? (src == 0) : (src != 0);
    step(code, imm, src);
    exp_pc = taken ? exp_pc + imm : exp_pc + 32'd2;
    check(taken ? "R6 taken pc" : "R6 not-taken pc", pc_o, exp_pc);
    check("R6 we", {31'd0, link_we_o}, 32'd0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_i = 3'd2; imm_i = 32'h100; src_i = 32'h0; valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      check("R8 pc", pc_o, exp_pc);
      check("R8 we", {31'd0, link_we_o}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; op_i = 3'd0; imm_i = '0; src_i = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_seq(3'd0);
    t_jal(32'h0000_0100);
    t_j(32'hFFFF_FFC0);
    t_jr(32'h0000_1235);
    t_jalr(32'h0000_8001);
    t_idle();
    t_branch(3'd5, 32'hFFFF_FFF8, 32'h0);
    t_branch(3'd5, 32'h0000_0010, 32'h5);
    t_branch(3'd6, 32'h0000_0020, 32'h1);
    t_branch(3'd6, 32'h0000_0020, 32'h0);
    t_seq(3'd7);
    t_jr(32'hFFFF_FFFF);
    t_seq(3'd0);
    check("R9 wrap", pc_o, 32'h0000_0000);
    t_j(32'hFFFF_FFFE);
    check("R9 neg wrap", pc_o, 32'hFFFF_FFFE);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule